// File: doc/BRIEF.md
# Divisor-Keyed Reciprocal Result Cache

This block sits beside a multiplication-based iterative divider and remembers reciprocals of recently used divisors. When a division is issued, the divisor's stored 52-bit fraction is presented on the lookup port in the same cycle the divider starts. One cycle later the block answers hit or miss. On a hit it also returns the stored 55-bit word, so the divider can cancel its iterations and go straight to the multiply by the dividend. On a miss the divider runs to completion and writes the reciprocal it produced through the fill port.

The search is fully associative over a parameterised number of entries (128 by default). The match key is the divisor fraction alone. Sign and exponent never reach the block, because the mantissa path runs independently of the exponent path. Each stored word keeps the reciprocal fraction and three extra rounding bits, so a later hit can be rounded correctly under any rounding mode. The search cannot tell a reciprocal apart from any other result, so only reciprocals are ever filled. A flush input drops every entry in one cycle.

Top module: `recip_cache`

## Requirements
- R1: After reset `rsp_valid` is low and no entry is valid, so the first lookup of any fraction reports a miss.
- R2: A lookup presented with `lk_valid` high on one rising edge produces exactly one response, with `rsp_valid` high during the following cycle. In a cycle after an edge with no lookup, `rsp_valid` is low.
- R3: A hit returns the full 55-bit word most recently filled for that fraction. Bits 54:3 hold the reciprocal fraction, bit 2 the guard bit, bit 1 the round bit and bit 0 the sticky bit. A miss returns all zeros on `rsp_recip`.
- R4: Matching compares all 52 fraction bits. A key that differs from a stored fraction in any single bit, including bit 0 or bit 51, is a miss.
- R5: A fill accepted on one edge is visible to a lookup presented on the next edge.
- R6: While any entry is invalid, a fill with a new fraction takes the invalid entry with the lowest index and evicts nothing. After N distinct fills into an empty cache of N entries, all N fractions hit.
- R7: When every entry is valid, a fill with a new fraction replaces entries in round-robin order, starting at index 0. Into a cache filled in order from empty, successive new fills therefore evict fractions in the order they were first filled.
- R8: A fill whose fraction matches a valid entry overwrites that entry's word in place. It creates no duplicate, evicts nothing and does not advance the round-robin position.
- R9: When a lookup and a fill carry the same fraction on the same edge, the lookup reports a miss. The fill still completes, and a lookup on the next edge hits with the filled word.
- R10: On the edge where `flush` is high, every entry becomes invalid and the round-robin position returns to index 0. A lookup on that edge misses, and a fill on that edge is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Invalidate every entry and reset the replacement position |
| lk_valid | input | 1 | Lookup request, asserted with the divider start |
| lk_frac | input | 52 | Divisor fraction to search for |
| fill_valid | input | 1 | Write a computed reciprocal |
| fill_frac | input | 52 | Divisor fraction that keys the written entry |
| fill_recip | input | 55 | Reciprocal fraction followed by guard, round and sticky bits |
| rsp_valid | output | 1 | Response to the lookup of the previous edge |
| rsp_hit | output | 1 | The looked-up fraction was found |
| rsp_recip | output | 55 | Stored word on a hit, zero on a miss |

## Verification
The assertions assume the divider issues at most one lookup and one fill per cycle. They also assume a fill key never equals a valid entry's key in more than one place, which holds only if every write goes through the fill port after reset or flush. The stimulus drives all inputs on the falling edge. It uses distinct fractions built from an index, except where a test repeats a fraction on purpose to reach the overwrite or same-cycle cases. It holds `flush` high for one cycle at a time, with or without a lookup and fill beside it.

// File: rtl/rc_pkg.sv
package rc_pkg;
   localparam int unsigned RC_FRAC_W = 52;
   localparam int unsigned RC_RND_W  = 3;
   localparam int unsigned RC_WORD_W = RC_FRAC_W + RC_RND_W;

   typedef enum logic [1:0] {
      WR_OVERWRITE = 2'd0,
      WR_FREE      = 2'd1,
      WR_VICTIM    = 2'd2
   } wr_sel_e;
endpackage

// File: rtl/rc_match.sv
module rc_match #(
   parameter int unsigned ENTRIES = 128,
   parameter int unsigned KEY_W   = 52
) (
   input  logic [ENTRIES-1:0]            valid,
   input  logic [ENTRIES-1:0][KEY_W-1:0] keys,
   input  logic [KEY_W-1:0]              probe,
   output logic [ENTRIES-1:0]            hit
);
   for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
      assign hit[e] = valid[e] && (keys[e] == probe);
   end
endmodule

// File: rtl/rc_first_set.sv
module rc_first_set #(
   parameter int unsigned WIDTH = 128,
   localparam int unsigned IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
   input  logic [WIDTH-1:0] vec,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = WIDTH - 1; i >= 0; i--) begin
         if (vec[i]) idx = IDX_W'(i);
      end
   end
   assign any = |vec;
endmodule

// File: rtl/rc_victim.sv
module rc_victim #(
   parameter int unsigned ENTRIES = 128,
   localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             advance,
   output logic [IDX_W-1:0] ptr
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

   logic [IDX_W-1:0] ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ptr_q <= '0;
      else if (clear)   ptr_q <= '0;
      else if (advance) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
   end
   assign ptr = ptr_q;

   AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_q <= LAST); // R7
   AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> ptr_q == '0); // R10
endmodule

// File: rtl/recip_cache.sv
module recip_cache
   import rc_pkg::*;
#(
   parameter int unsigned ENTRIES = 128,
   parameter int unsigned FRAC_W  = RC_FRAC_W,
   parameter int unsigned RND_W   = RC_RND_W,
   localparam int unsigned WORD_W = FRAC_W + RND_W,
   localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              lk_valid,
   input  logic [FRAC_W-1:0] lk_frac,
   input  logic              fill_valid,
   input  logic [FRAC_W-1:0] fill_frac,
   input  logic [WORD_W-1:0] fill_recip,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic [WORD_W-1:0] rsp_recip
);
   if (ENTRIES < 2) begin : g_bad_entries
      $error("recip_cache: ENTRIES must be at least 2");
   end
   if (FRAC_W < 2) begin : g_bad_frac
      $error("recip_cache: FRAC_W must be at least 2");
   end
   if (RND_W < 1) begin : g_bad_rnd
      $error("recip_cache: RND_W must be at least 1");
   end

   logic [ENTRIES-1:0]             valid_q;
   logic [ENTRIES-1:0][FRAC_W-1:0] tag_q;
   logic [ENTRIES-1:0][WORD_W-1:0] word_q;

   logic [ENTRIES-1:0] lk_hitv, fill_hitv;
   logic               lk_any, fill_any, free_any;
   logic [IDX_W-1:0]   lk_idx, fill_idx, free_idx, victim_idx, wr_idx;
   wr_sel_e            wr_sel;
   logic               fill_en, collide, hit_d;

   rc_match #(.ENTRIES(ENTRIES), .KEY_W(FRAC_W)) u_lk_match (
      .valid(valid_q), .keys(tag_q), .probe(lk_frac), .hit(lk_hitv));
   rc_match #(.ENTRIES(ENTRIES), .KEY_W(FRAC_W)) u_fill_match (
      .valid(valid_q), .keys(tag_q), .probe(fill_frac), .hit(fill_hitv));

   rc_first_set #(.WIDTH(ENTRIES)) u_lk_enc (
      .vec(lk_hitv), .any(lk_any), .idx(lk_idx));
   rc_first_set #(.WIDTH(ENTRIES)) u_fill_enc (
      .vec(fill_hitv), .any(fill_any), .idx(fill_idx));
   rc_first_set #(.WIDTH(ENTRIES)) u_free_enc (
      .vec(~valid_q), .any(free_any), .idx(free_idx));

   assign fill_en = fill_valid && !flush;

   always_comb begin
      if (fill_any)      wr_sel = WR_OVERWRITE;
      else if (free_any) wr_sel = WR_FREE;
      else               wr_sel = WR_VICTIM;
      unique case (wr_sel)
         WR_OVERWRITE: wr_idx = fill_idx;
         WR_FREE:      wr_idx = free_idx;
         default:      wr_idx = victim_idx;
      endcase
   end

   rc_victim #(.ENTRIES(ENTRIES)) u_victim (
      .clk(clk), .rst_n(rst_n), .clear(flush),
      .advance(fill_en && (wr_sel == WR_VICTIM)),
      .ptr(victim_idx));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       valid_q <= '0;
      else if (flush)   valid_q <= '0;
      else if (fill_en) valid_q[wr_idx] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (fill_en) begin
         tag_q[wr_idx]  <= fill_frac;
         word_q[wr_idx] <= fill_recip;
      end
   end

   assign collide = fill_valid && (fill_frac == lk_frac);
   assign hit_d   = lk_valid && lk_any && !collide && !flush;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_recip <= '0;
      end else begin
         rsp_valid <= lk_valid;
         rsp_hit   <= hit_d;
         rsp_recip <= hit_d ? word_q[lk_idx] : '0;
      end
   end

   AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> rsp_valid); // R2
   AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> !rsp_valid); // R2
   AST_HIT_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> rsp_valid); // R2
   AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_hit) |-> rsp_recip == '0); // R3
   AST_SINGLE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_hitv) && $onehot0(fill_hitv)); // R8
   AST_COLLIDE_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && fill_valid && lk_frac == fill_frac) |=> !rsp_hit); // R9
   AST_FLUSH_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && lk_valid) |=> !rsp_hit); // R10
   AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> valid_q == '0); // R10
endmodule

// File: tb/recip_cache_tb.sv
module recip_cache_tb;
   localparam int unsigned CLK_PERIOD = 10;
   localparam int unsigned N  = 128;
   localparam int unsigned FW = 52;
   localparam int unsigned WW = 55;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          flush = 1'b0;
   logic          lk_valid = 1'b0;
   logic [FW-1:0] lk_frac = '0;
   logic          fill_valid = 1'b0;
   logic [FW-1:0] fill_frac = '0;
   logic [WW-1:0] fill_recip = '0;
   logic          rsp_valid, rsp_hit;
   logic [WW-1:0] rsp_recip;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      bit            vld;
      bit            hit;
      logic [WW-1:0] word;
      string         req;
   } exp_t;
   exp_t sb[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   recip_cache u_dut (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .lk_valid(lk_valid), .lk_frac(lk_frac),
      .fill_valid(fill_valid), .fill_frac(fill_frac), .fill_recip(fill_recip),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_recip(rsp_recip));

   function automatic logic [FW-1:0] key(int i);
      return {20'h3C5A9, 32'(i * 97 + 11)};
   endfunction

   function automatic logic [WW-1:0] wd(int i, int salt);
      return {23'h51A2B, 32'(i * 13 + salt)};
   endfunction

   // One cycle of stimulus; queues the expected response (or expected idle).
   task automatic step(bit lv, logic [FW-1:0] lf, bit fv, logic [FW-1:0] ff,
                       logic [WW-1:0] fd, bit fl, bit ehit,
                       logic [WW-1:0] eword, string req);
      exp_t e;
      @(negedge clk);
      lk_valid = lv; lk_frac = lf;
      fill_valid = fv; fill_frac = ff; fill_recip = fd;
      flush = fl;
      e.vld = lv; e.hit = lv && ehit; e.word = (lv && ehit) ? eword : '0; e.req = req;
      sb.push_back(e);
   endtask

   task automatic look(logic [FW-1:0] f, bit ehit, logic [WW-1:0] ew, string req);
      step(1'b1, f, 1'b0, '0, '0, 1'b0, ehit, ew, req);
   endtask

   task automatic fill(logic [FW-1:0] f, logic [WW-1:0] d);
      step(1'b0, '0, 1'b1, f, d, 1'b0, 1'b0, '0, "R2");
   endtask

   task automatic idle();
      step(1'b0, '0, 1'b0, '0, '0, 1'b0, 1'b0, '0, "R2");
   endtask

   // Monitor: compares each cycle's response against the scoreboard.
   initial begin
      exp_t e;
      @(posedge rst_n);
      forever begin
         @(posedge clk);
         #1;
         if (sb.size() != 0) begin
            e = sb.pop_front();
            checks++;
            if (rsp_valid !== e.vld || rsp_hit !== e.hit ||
                (e.vld && rsp_recip !== e.word)) begin
               errors++;
               $display("FAIL %s: valid/hit/word = %0b/%0b/%h expected %0b/%0b/%h",
                        e.req, rsp_valid, rsp_hit, rsp_recip, e.vld, e.hit, e.word);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if (rsp_valid !== 1'b0) begin
         errors++;
         $display("FAIL R1: rsp_valid in reset = %0b expected 0", rsp_valid);
      end
      rst_n = 1'b1;

      // R1 empty after reset, R3 miss word zero
      look(key(0), 0, '0, "R1");
      idle();
      // R5 fill then hit, R3 full word returned
      fill(key(0), wd(0, 1));
      look(key(0), 1, wd(0, 1), "R5");
      // R4 single-bit differences miss
      look(key(0) ^ 52'h1, 0, '0, "R4");
      look(key(0) ^ (52'h1 << 51), 0, '0, "R4");
      // R9 same-edge lookup and fill of one fraction
      step(1, key(1), 1, key(1), wd(1, 1), 0, 0, '0, "R9");
      look(key(1), 1, wd(1, 1), "R9");
      // R6 fill the rest, no eviction while free slots remain
      for (int i = 2; i < N; i++) fill(key(i), wd(i, 1));
      for (int i = 0; i < N; i++) look(key(i), 1, wd(i, 1), "R6");
      // R8 overwrite in place
      fill(key(5), wd(5, 77));
      look(key(5), 1, wd(5, 77), "R8");
      look(key(0), 1, wd(0, 1), "R8");
      // R7 round robin from index 0, untouched by the overwrite (R8)
      fill(key(1000), wd(1000, 1));
      look(key(0), 0, '0, "R7");
      look(key(1000), 1, wd(1000, 1), "R7");
      look(key(1), 1, wd(1, 1), "R7");
      fill(key(1001), wd(1001, 1));
      look(key(1), 0, '0, "R7");
      look(key(2), 1, wd(2, 1), "R7");
      look(key(5), 1, wd(5, 77), "R8");
      // R10 flush with lookup and fill on the same edge
      step(1, key(2), 1, key(2000), wd(2000, 1), 1, 0, '0, "R10");
      look(key(2000), 0, '0, "R10");
      look(key(3), 0, '0, "R10");
      look(key(1000), 0, '0, "R10");
      // R10 round-robin position restarts at index 0
      for (int i = 0; i < N; i++) fill(key(3000 + i), wd(3000 + i, 3));
      fill(key(5000), wd(5000, 3));
      look(key(3000), 0, '0, "R10");
      look(key(3001), 1, wd(3001, 3), "R10");
      look(key(5000), 1, wd(5000, 3), "R10");
      idle();
      idle();
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule